// File: doc/BRIEF.md
# Bus Error Capture Registers

This block freezes a snapshot of the bus when the active-low channel-check error input asserts. The snapshot holds bus address bits 30 down to 2, the data/command qualifier, the arbitrate/grant level and the four arbitration priority lines. Error-handling software can then read it back at any time through six byte-wide registers. The error input is asynchronous. It passes through a two-flop synchroniser, and the capture fires on the synchronised high-to-low transition.

Only the first error is kept. Once a snapshot is taken, a valid flag rises and every later error edge is ignored. This lasts until software pulses the clear strobe or reset is applied. Both of these zero the snapshot and drop the flag. After a clear, the block captures again only on a fresh falling edge of the error input. An error level that is still held low does not count. Register reads are combinational from a select input, and any unused bit reads as zero.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, `valid_o` is 0 and every select value 0 to 7 reads 0.
- R2: When `chk_err_ni` is first sampled low at rising edge E0, the bus inputs present at edge E2 are captured. `valid_o` is 0 after E1 and 1 after E2.
- R3: Address fields: select 0 gives bits 30..24 in data bits 6..0 with bit 7 zero. Select 1 gives bits 23..16. Select 2 gives bits 15..8. Select 3 gives bits 7..2 in data bits 7..2, with data bits 1..0 zero.
- R4: Select 4 gives the arbitration lines in data bits 3..0 and the arbitrate/grant level in data bit 4 (1 = arbitrating, 0 = granted). Data bits 7..5 are zero.
- R5: Select 5 gives the data/command qualifier in data bit 0 (1 = data, 0 = command), with the other bits zero. Selects 6 and 7 read 0.
- R6: While `valid_o` is 1, further falling edges of the error input and changes on the bus inputs leave all register contents unchanged.
- R7: `clear_i` high at a rising edge zeroes the snapshot and `valid_o`. It takes priority over a capture due at the same edge.
- R8: After a clear, an error input that stays low causes no capture. Only a new high-to-low transition re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chk_err_ni | input | 1 | Asynchronous active-low channel-check error |
| clear_i | input | 1 | Synchronous clear of the snapshot and the valid flag |
| bus_addr_i | input | 29 | Live bus address bits 30..2 |
| bus_dc_i | input | 1 | Data (1) or command (0) qualifier |
| bus_arb_gnt_i | input | 1 | Arbitrating (1) or granted (0) |
| bus_arb_lvl_i | input | 4 | Arbitration priority lines |
| rd_sel_i | input | 3 | Register select |
| rd_data_o | output | 8 | Selected register contents |
| valid_o | output | 1 | Snapshot held |

## Verification
The bus is driven with a different value in each cycle around the error edge. Because of this, only a capture at the synchroniser's exact latency yields the expected snapshot, and one cycle early or late shows a different pattern. Two field patterns with opposite qualifier and arbitrate/grant levels and complementary-looking address bits are read through all eight selects, which exposes swapped or misplaced fields. A second error edge with changed bus values checks the hold, and a clear with the error still low checks the re-arm. A clear placed on the capture edge checks the priority.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int ADDR_HI = 30;
  localparam int ADDR_LO = 2;
  localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
  localparam int ARB_W   = 4;
  localparam int REG_W   = 8;
  localparam int NUM_REGS = 6;
  localparam int SEL_W   = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              dc;
    logic              arb_gnt;
    logic [ARB_W-1:0]  arb;
  } snap_t;
endpackage

// File: rtl/bec_sync.sv
module bec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop, all idle high
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-1:0], async_ni};
  end

  assign fall_o = q[STAGES] & ~q[STAGES-1];

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/bec_capture.sv
module bec_capture
  import bec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fall_i,
  input  logic  clear_i,
  input  snap_t bus_i,
  output snap_t snap_o,
  output logic  valid_o
);
  snap_t snap_q;
  logic  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else if (fall_i && !valid_q) begin
      snap_q  <= bus_i;
      valid_q <= 1'b1;
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = valid_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !clear_i |=> valid_q && $stable(snap_q));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_q && (snap_q == '0));
endmodule

// File: rtl/bec_readout.sv
module bec_readout
  import bec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  snap_t            snap_i,
  output logic [REG_W-1:0] rd_data_o
);
  localparam logic [SEL_W-1:0] SEL_A_TOP = 3'd0;
  localparam logic [SEL_W-1:0] SEL_A_HI  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_A_MID = 3'd2;
  localparam logic [SEL_W-1:0] SEL_A_LOW = 3'd3;
  localparam logic [SEL_W-1:0] SEL_ARB   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_QUAL  = 3'd5;

  logic [ADDR_HI:ADDR_LO] a;
  assign a = snap_i.addr;

  always_comb begin
    rd_data_o = '0;
    unique case (sel_i)
      SEL_A_TOP: rd_data_o = {1'b0, a[30:24]};
      SEL_A_HI:  rd_data_o = a[23:16];
      SEL_A_MID: rd_data_o = a[15:8];
      SEL_A_LOW: rd_data_o = {a[7:2], 2'b00};
      SEL_ARB:   rd_data_o = {3'b000, snap_i.arb_gnt, snap_i.arb};
      SEL_QUAL:  rd_data_o = {7'b0, snap_i.dc};
      default:   rd_data_o = '0;
    endcase
  end

  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_i) >= NUM_REGS) |-> (rd_data_o == '0));

  assert_arb_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_ARB) |-> (rd_data_o[7:5] == 3'b000));

  assert_low_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_A_LOW) |-> (rd_data_o[1:0] == 2'b00));
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   chk_err_ni,
  input  logic                   clear_i,
  input  logic [ADDR_HI:ADDR_LO] bus_addr_i,
  input  logic                   bus_dc_i,
  input  logic                   bus_arb_gnt_i,
  input  logic [ARB_W-1:0]       bus_arb_lvl_i,
  input  logic [SEL_W-1:0]       rd_sel_i,
  output logic [REG_W-1:0]       rd_data_o,
  output logic                   valid_o
);
  logic  fall;
  snap_t bus, snap;

  assign bus = '{addr: bus_addr_i, dc: bus_dc_i, arb_gnt: bus_arb_gnt_i, arb: bus_arb_lvl_i};

  bec_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_ni(chk_err_ni), .fall_o(fall)
  );

  bec_capture i_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .clear_i(clear_i),
    .bus_i(bus), .snap_o(snap), .valid_o(valid_o)
  );

  bec_readout i_readout (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(rd_sel_i), .snap_i(snap), .rd_data_o(rd_data_o)
  );

  // captures only on a transition, never while already holding (R8, R6)
  assert_capture_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(fall) && !$past(clear_i));
endmodule

// File: tb/test_bus_err_capture.sv
`timescale 1ns/1ps
module test_bus_err_capture;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic chk_err_ni = 1'b1;
  logic clear_i = 1'b0;
  logic [30:2] bus_addr_i = '0;
  logic bus_dc_i = 1'b0;
  logic bus_arb_gnt_i = 1'b0;
  logic [3:0] bus_arb_lvl_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic valid_o;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  bus_err_capture i_bus_err_capture (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [30:2] a, input logic dc, input logic ag, input logic [3:0] arb);
    bus_addr_i = a; bus_dc_i = dc; bus_arb_gnt_i = ag; bus_arb_lvl_i = arb;
  endtask

  task automatic read_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk_i);
    rd_sel_i = s;
    #0.5;
    d = rd_data_o;
  endtask

  function automatic logic [7:0] exp_reg(input logic [2:0] s, input logic [30:2] a,
                                         input logic dc, input logic ag, input logic [3:0] arb);
    case (s)
      3'd0: return {1'b0, a[30:24]};
      3'd1: return a[23:16];
      3'd2: return a[15:8];
      3'd3: return {a[7:2], 2'b00};
      3'd4: return {3'b000, ag, arb};
      3'd5: return {7'b0, dc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_all(input string req, input logic [30:2] a, input logic dc,
                           input logic ag, input logic [3:0] arb);
    logic [7:0] d;
    for (int s = 0; s < 8; s++) begin
      read_reg(3'(s), d);
      check($sformatf("%s sel%0d", req, s), {24'b0, d}, {24'b0, exp_reg(3'(s), a, dc, ag, arb)});
    end
  endtask

  localparam logic [30:2] PAT_A = 29'h0AAA_5551;
  localparam logic [30:2] PAT_B = 29'h1234_5678;
  localparam logic [30:2] PAT_C = 29'h15C3_9E6B;
  localparam logic [30:2] PAT_D = 29'h0F0F_0F0F;
  localparam logic [30:2] PAT_E = 29'h1E5A_A5C7;

  task automatic t_reset();
    check("R1 valid", {31'b0, valid_o}, 32'd0);
    check_all("R1", '0, 1'b0, 1'b0, 4'h0);
  endtask

  // chk low sampled at E0; capture at E2 with bus of that cycle (pattern C)
  task automatic t_capture_timing();
    @(negedge clk_i);
    chk_err_ni = 1'b0; drive(PAT_A, 1'b0, 1'b0, 4'h1);
    @(negedge clk_i);
    drive(PAT_B, 1'b0, 1'b0, 4'h2);
    @(negedge clk_i);
    check("R2 valid before capture", {31'b0, valid_o}, 32'd0);
    drive(PAT_C, 1'b1, 1'b0, 4'hA);
    @(negedge clk_i);
    check("R2 valid after capture", {31'b0, valid_o}, 32'd1);
    drive(PAT_D, 1'b0, 1'b1, 4'h5);
    check_all("R2 R3 R4 R5 pattern C", PAT_C, 1'b1, 1'b0, 4'hA);
  endtask

  task automatic t_hold();
    chk_err_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_err_ni = 1'b0; drive(PAT_B, 1'b0, 1'b1, 4'h3);
    repeat (6) @(negedge clk_i);
    check("R6 valid held", {31'b0, valid_o}, 32'd1);
    check_all("R6 first error kept", PAT_C, 1'b1, 1'b0, 4'hA);
  endtask

  task automatic t_clear_rearm();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    check("R7 valid cleared", {31'b0, valid_o}, 32'd0);
    check_all("R7 zeroed", '0, 1'b0, 1'b0, 4'h0);
    drive(PAT_E, 1'b0, 1'b1, 4'hF);
    repeat (6) @(negedge clk_i);
    check("R8 held-low no capture", {31'b0, valid_o}, 32'd0);
    check_all("R8 still zero", '0, 1'b0, 1'b0, 4'h0);
    chk_err_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_err_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R8 rearmed capture", {31'b0, valid_o}, 32'd1);
    check_all("R3 R4 R5 pattern E", PAT_E, 1'b0, 1'b1, 4'hF);
  endtask

  task automatic t_clear_priority();
    @(negedge clk_i);
    clear_i = 1'b1; chk_err_ni = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk_err_ni = 1'b0; drive(PAT_A, 1'b1, 1'b1, 4'h7);
    @(negedge clk_i);
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    check("R7 clear beats capture", {31'b0, valid_o}, 32'd0);
    repeat (4) @(negedge clk_i);
    check("R7 no late capture", {31'b0, valid_o}, 32'd0);
    check_all("R7 snapshot empty", '0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_capture_timing();
    t_hold();
    t_clear_rearm();
    t_clear_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule